// File: doc/BRIEF.md
# Fractional-Divide Baud Clock Generator

This block turns a fast system clock into two periodic one-cycle enable ticks. One paces an infrared sampler at about 1.8432 MHz. The other runs at sixteen times a UART bit rate. Each tick has its own pair of settings: an integer count and a 4-bit fraction in sixteenths. The long-term divide ratio is therefore an integer plus a fraction. The fraction is applied by making selected output periods one system clock longer. Over every sixteen periods the average ratio is exact.

Software programs the settings through a simple write strobe with a two-bit register select. A write to a channel's settings restarts that channel cleanly. The other channel keeps running undisturbed. An infrared count of zero is illegal. In that case the block raises an error flag and holds the infrared tick low.

Top module: `fbg_top`

## Requirements
- R1: With fraction 0, the infrared tick is high for one system clock every (C+1) clocks, where C is the infrared count register (select 0, data bits 3:0).
- R2: With fraction 0, the UART tick is high for one clock every (U+1)×16 clocks, where U is the UART count register (select 2, data bits 7:0).
- R3: A fraction F (0..15) lengthens selected periods by one clock. A 4-bit accumulator starts at 0 and adds F at the end of every period. Period k (k = 0 after a restart) lasts B+1 clocks when (k×F mod 16) + F ≥ 16, and B clocks otherwise. B is the channel's integer base.
- R4: A write to a channel's register restarts that channel. The accumulator returns to 0, and no tick appears until exactly B clocks after the clock edge that took the write. There is then no truncated or doubled tick.
- R5: While the infrared count register holds 0, ir_cfg_err is 1 and ir_tick stays 0.
- R6: The fraction is taken from write data bits 7:4 (select 1 for infrared, select 3 for UART). Bits 3:0 of a fraction write have no effect.
- R7: After reset all registers are 0. ir_cfg_err is 1, and ir_tick is 0.
- R8: A write to one channel's registers does not restart or alter the other channel's tick sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 IR count, 1 IR fraction, 2 UART count, 3 UART fraction |
| wr_data | input | 8 | Write data |
| ir_tick | output | 1 | Infrared sampling enable tick |
| uart_tick | output | 1 | 16x UART bit enable tick |
| ir_cfg_err | output | 1 | Infrared count is zero (illegal) |

## Verification
The bench predicts every tick's exact cycle from the written settings and compares each arrival. This exposes a divider that is off by one in its reload. The same comparison catches an accumulator that drops or misplaces carries, or that takes the fraction from the wrong nibble. The first tick after each write is timed against the write edge. A design that failed to restart would show a short or doubled first period. UART ticks are checked across infrared writes, so a shared restart would break that schedule. A zero infrared count is held for a long window: any tick in it, or a clear error flag, reveals a missing guard.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic [1:0] {
        SEL_IR_CNT  = 2'd0,
        SEL_IR_FRAC = 2'd1,
        SEL_UA_CNT  = 2'd2,
        SEL_UA_FRAC = 2'd3
    } sel_e;

    localparam int FRAC_W = 4;
    localparam int IR_CNT_W = 4;

    typedef struct packed {
        logic [FRAC_W-1:0]   frac;
        logic [IR_CNT_W-1:0] cnt;
    } ir_cfg_t;

    function automatic logic frac_carry(input logic [FRAC_W-1:0] acc,
                                        input logic [FRAC_W-1:0] frac);
        logic [FRAC_W:0] sum;
        sum = {1'b0, acc} + {1'b0, frac};
        return sum[FRAC_W];
    endfunction

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int UA_CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output ir_cfg_t             ir_cfg,
    output logic [UA_CNT_W-1:0] ua_cnt,
    output logic [FRAC_W-1:0]   ua_frac,
    output logic                ir_restart,
    output logic                ua_restart
);
    sel_e sel;
    assign sel = sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_cfg     <= '0;
            ua_cnt     <= '0;
            ua_frac    <= '0;
            ir_restart <= 1'b1;
            ua_restart <= 1'b1;
        end else begin
            ir_restart <= wr_en && (sel == SEL_IR_CNT || sel == SEL_IR_FRAC);
            ua_restart <= wr_en && (sel == SEL_UA_CNT || sel == SEL_UA_FRAC);
            if (wr_en) begin
                case (sel)
                    SEL_IR_CNT:  ir_cfg.cnt  <= wr_data[IR_CNT_W-1:0];
                    SEL_IR_FRAC: ir_cfg.frac <= wr_data[7:4];
                    SEL_UA_CNT:  ua_cnt      <= wr_data[UA_CNT_W-1:0];
                    SEL_UA_FRAC: ua_frac     <= wr_data[7:4];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fbg_chan.sv
module fbg_chan
    import fbg_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int SCALE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              enable,
    input  logic [CNT_W-1:0]  cnt_reg,
    input  logic [FRAC_W-1:0] frac,
    output logic              tick
);
    localparam int SH     = $clog2(SCALE);
    localparam int BASE_W = CNT_W + 1 + SH;

    logic [BASE_W-1:0] base;
    logic [BASE_W-1:0] cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] acc_nx;
    logic              stretch;

    always_comb begin
        base    = (BASE_W'(cnt_reg) + BASE_W'(1)) << SH;
        acc_nx  = acc + frac;
        stretch = frac_carry(acc_nx, frac);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            cnt <= base - BASE_W'(1);
            acc <= '0;
        end else if (cnt == '0) begin
            acc <= acc_nx;
            cnt <= base + BASE_W'(stretch) - BASE_W'(1);
        end else begin
            cnt <= cnt - BASE_W'(1);
        end
    end

    assign tick = enable && !restart && (cnt == '0);
endmodule

// File: rtl/fbg_top.sv
module fbg_top
    import fbg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int UA_CNT_W = 8,
    parameter int UA_SCALE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ir_tick,
    output logic              uart_tick,
    output logic              ir_cfg_err
);
    ir_cfg_t             ir_cfg;
    logic [UA_CNT_W-1:0] ua_cnt;
    logic [FRAC_W-1:0]   ua_frac;
    logic                ir_restart;
    logic                ua_restart;

    fbg_regs #(.DATA_W(DATA_W), .UA_CNT_W(UA_CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ir_cfg(ir_cfg), .ua_cnt(ua_cnt), .ua_frac(ua_frac),
        .ir_restart(ir_restart), .ua_restart(ua_restart)
    );

    assign ir_cfg_err = (ir_cfg.cnt == '0);

    fbg_chan #(.CNT_W(IR_CNT_W), .SCALE(1)) u_ir (
        .clk(clk), .rst(rst), .restart(ir_restart), .enable(!ir_cfg_err),
        .cnt_reg(ir_cfg.cnt), .frac(ir_cfg.frac), .tick(ir_tick)
    );

    fbg_chan #(.CNT_W(UA_CNT_W), .SCALE(UA_SCALE)) u_ua (
        .clk(clk), .rst(rst), .restart(ua_restart), .enable(1'b1),
        .cnt_reg(ua_cnt), .frac(ua_frac), .tick(uart_tick)
    );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       ir_tick,
    input logic       uart_tick,
    input logic       ir_cfg_err
);
    a_r5_no_tick_on_err: assert property (@(posedge clk) disable iff (rst)
        ir_cfg_err |-> !ir_tick);

    a_r4_ir_quiet_after_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel[1]) |=> !ir_tick);

    a_r4_ua_quiet_after_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel[1]) |=> !uart_tick);

    a_r1_ir_single_cycle: assert property (@(posedge clk) disable iff (rst)
        ir_tick |=> !ir_tick);

    a_r2_ua_single_cycle: assert property (@(posedge clk) disable iff (rst)
        uart_tick |=> !uart_tick);
endmodule

bind fbg_top fbg_checker u_fbg_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .ir_tick(ir_tick), .uart_tick(uart_tick), .ir_cfg_err(ir_cfg_err)
);

// File: tb/fbg_top_bench.sv
module fbg_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       ir_tick, uart_tick, ir_cfg_err;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int ir_q[$], ua_q[$];
    string ir_tq[$], ua_tq[$];
    bit ir_strict = 0, ua_strict = 0;
    int ir_unexp = 0;

    fbg_top u_fbg_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ir_tick(ir_tick), .uart_tick(uart_tick), .ir_cfg_err(ir_cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns the edge number that took the write
    task automatic wr(input logic [1:0] sel, input logic [7:0] d, output int edge_n);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        edge_n = cyc;
    endtask

    task automatic sched(input bit ua, input int base, input int fr, input int n,
                         input int start, input string tag);
        int t;
        t = start + base;
        for (int k = 0; k < n; k++) begin
            string tg;
            tg = (k == 0) ? "R4 first tick" : tag;
            if (ua) begin ua_q.push_back(t); ua_tq.push_back(tg); end
            else    begin ir_q.push_back(t); ir_tq.push_back(tg); end
            t = t + base + ((((((k + 1) * fr) % 16) + fr) >= 16) ? 1 : 0);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (ir_tick) begin
                if (ir_q.size() > 0) begin
                    int e; string tg;
                    e = ir_q.pop_front(); tg = ir_tq.pop_front();
                    check(cyc == e, {tg, " ir"}, cyc, e);
                end else if (ir_strict) begin
                    ir_unexp++;
                end
            end
            if (uart_tick) begin
                if (ua_q.size() > 0) begin
                    int e; string tg;
                    e = ua_q.pop_front(); tg = ua_tq.pop_front();
                    check(cyc == e, {tg, " uart"}, cyc, e);
                end else if (ua_strict) begin
                    check(0, "R8 unexpected uart tick", cyc, -1);
                end
            end
        end
    end

    task automatic run_tests;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ir_cfg_err == 1'b1, "R7 reset err flag", ir_cfg_err, 1);
        check(ir_tick == 1'b0, "R7 reset ir tick", ir_tick, 0);

        // R1: integer-only infrared divide, base 4
        wr(2'd0, 8'h03, n);
        check(ir_cfg_err == 1'b0, "R5 err clears", ir_cfg_err, 0);
        sched(0, 4, 0, 16, n, "R1 period");
        ir_strict = 1; ir_unexp = 0;
        wait (ir_q.size() == 0);
        @(negedge clk);
        check(ir_unexp == 0, "R1 extra ir ticks", ir_unexp, 0);
        ir_strict = 0;

        // R3/R6: base 5, fraction 5, low nibble garbage
        wr(2'd0, 8'h04, n);
        wr(2'd1, 8'h5F, n);
        sched(0, 5, 5, 32, n, "R3 R6 frac period");
        ir_strict = 1; ir_unexp = 0;
        wait (ir_q.size() == 0);
        @(negedge clk);
        check(ir_unexp == 0, "R3 extra ir ticks", ir_unexp, 0);
        ir_strict = 0;

        // R2/R3 with R8: UART base 48 fraction 3, infrared writes meanwhile
        wr(2'd2, 8'h02, n);
        wr(2'd3, 8'h30, n);
        sched(1, 48, 3, 20, n, "R2 R3 R8 uart period");
        ua_strict = 1;
        repeat (100) @(negedge clk);
        wr(2'd0, 8'h06, n);
        repeat (200) @(negedge clk);
        wr(2'd1, 8'hA0, n);
        wait (ua_q.size() == 0);
        ua_strict = 0;

        // R2: UART base 16, fraction 0
        wr(2'd3, 8'h00, n);
        wr(2'd2, 8'h00, n);
        sched(1, 16, 0, 10, n, "R2 period");
        ua_strict = 1;
        wait (ua_q.size() == 0);
        ua_strict = 0;

        // R3: fraction 15 on infrared base 2
        wr(2'd0, 8'h01, n);
        wr(2'd1, 8'hF0, n);
        sched(0, 2, 15, 32, n, "R3 frac15 period");
        ir_strict = 1; ir_unexp = 0;
        wait (ir_q.size() == 0);
        @(negedge clk);
        check(ir_unexp == 0, "R3 extra ir ticks f15", ir_unexp, 0);
        ir_strict = 0;

        // R5: zero infrared count
        wr(2'd0, 8'h00, n);
        check(ir_cfg_err == 1'b1, "R5 err flag", ir_cfg_err, 1);
        ir_strict = 1; ir_unexp = 0;
        repeat (200) @(negedge clk);
        check(ir_unexp == 0, "R5 ir ticks while illegal", ir_unexp, 0);
        ir_strict = 0;
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule